// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block turns a fast system clock into the timing references that an SPI
transfer engine needs. One configuration word carries three pairs of small codes.
One pair sets the serial clock period. The other two pairs set the lead interval
and the trail interval. The lead interval runs from chip-select assertion to the
first clock edge. The trail interval runs from the last clock edge to chip-select
release. Each interval length, and the clock period, is the product of a prescale
factor and a scale factor. Each factor is looked up from its own table, so there
is no single binary divisor.

The transfer engine holds `run_i` high while it wants a serial clock. It receives
a registered clock level and a one-cycle tick at every clock transition. To time
an interval, the engine pulses the matching start input and waits for the
one-cycle done pulse. The configuration word is captured only while the generator
is fully idle. A word that changes while a frame or an interval is in progress
therefore has no effect on that activity.

Top module: `sckgen_timing`

## Requirements
- R1: After reset, `sck_o`, `sck_tick_o`, `lead_done_o` and `trail_done_o` are all 0.
- R2: The serial clock period P, in system clocks, is the prescale factor times the scale factor.
  - The prescale code is in config bits 17:16: codes 0,1,2,3 give 2,3,5,7.
  - The scale code c is in bits 3:0: c<4 gives 2*(c+1), otherwise 2^c.
- R3: With H = floor(P/2) and L = P-H, `sck_o` first rises L cycles after `run_i` is sampled high. It then stays high for H cycles and low for L cycles, and repeats.
- R4: `sck_tick_o` is a one-cycle pulse in exactly the cycle in which `sck_o` has just changed. There is no tick while `sck_o` holds.
- R5: The lead interval D has a prescale code p in bits 23:22, giving 2p+1, and a scale code j in bits 15:12, giving 2^(j+1).
  - D is the prescale factor times the scale factor.
  - `lead_done_o` pulses for one cycle, D cycles after the clock edge that sampled `lead_start_i`.
- R6: The trail interval is formed the same way from bits 21:20 and 11:8. It is started by `trail_start_i` and signalled on `trail_done_o`.
- R7: A start that arrives while its interval is still counting restarts the interval. No done is issued for the abandoned count, and done follows D cycles after the new start.
- R8: A change of `cfg_i` while `run_i` is high or either interval is counting is ignored for that activity. The word is captured on the first clock edge at which the block is idle, and applies from the next activity.
- R9: When `run_i` is sampled low, `sck_o` is 0 after that edge. The next run begins again with a full L-cycle low phase.
- R10: The lead and trail intervals count independently and may overlap each other and the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Timing configuration word (code fields as in R2, R5, R6) |
| run_i | input | 1 | Serial clock enable from the transfer engine |
| lead_start_i | input | 1 | Load and start the lead interval |
| trail_start_i | input | 1 | Load and start the trail interval |
| sck_o | output | 1 | Registered serial clock level, 0 when idle |
| sck_tick_o | output | 1 | One-cycle pulse at each serial clock transition |
| lead_done_o | output | 1 | One-cycle pulse when the lead interval expires |
| trail_done_o | output | 1 | One-cycle pulse when the trail interval expires |

## Verification
A wrong table entry or a wrong product shows up as a misplaced edge on `sck_o`
within the first period of a run. It also shows up as a done pulse arriving early
or late within one interval length. A phase counter that is not cleared when a run
stops shortens the first low phase of the next run. A configuration register that
updates while busy stretches or shortens the very next phase or interval after
`cfg_i` changes. Every one of these faults therefore reaches the ports within a
single period or interval of the stimulus that exposes it.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;

  // Counter width that holds the longest product (7 * 65536).
  localparam int TG_CNT_W = 20;

  // Field positions inside the configuration word.
  localparam int LEAD_PRE_LSB  = 22;
  localparam int TRAIL_PRE_LSB = 20;
  localparam int BAUD_PRE_LSB  = 16;
  localparam int LEAD_SCL_LSB  = 12;
  localparam int TRAIL_SCL_LSB = 8;
  localparam int BAUD_SCL_LSB  = 0;

  // Baud prescale: odd primes plus two.
  function automatic logic [2:0] baud_pre_f(input logic [1:0] c);
    logic [2:0] r;
    case (c)
      2'd0:    r = 3'd2;
      2'd1:    r = 3'd3;
      2'd2:    r = 3'd5;
      default: r = 3'd7;
    endcase
    return r;
  endfunction

  // Baud scale: linear steps of two for low codes, then powers of two.
  function automatic logic [16:0] baud_scl_f(input logic [3:0] c);
    logic [16:0] r;
    if (c < 4'd4) r = {14'd0, c[1:0], 1'b0} + 17'd2;
    else          r = 17'd1 << c;
    return r;
  endfunction

  // Delay prescale: odd factors 1,3,5,7.
  function automatic logic [2:0] dly_pre_f(input logic [1:0] c);
    return {c, 1'b1};
  endfunction

  // Delay scale: two to the power (code + 1).
  function automatic logic [16:0] dly_scl_f(input logic [3:0] c);
    return 17'd2 << c;
  endfunction

endpackage

// File: rtl/tg_factor_decode.sv
`timescale 1ns/1ps
module tg_factor_decode #(
  parameter int CNT_W = tg_pkg::TG_CNT_W,
  parameter bit DELAY = 1'b0
) (
  input  logic [1:0]       pre_code,
  input  logic [3:0]       scl_code,
  output logic [CNT_W-1:0] length
);
  logic [2:0]  pre_f;
  logic [16:0] scl_f;

  generate
    if (DELAY) begin : g_delay
      assign pre_f = tg_pkg::dly_pre_f(pre_code);
      assign scl_f = tg_pkg::dly_scl_f(scl_code);
    end else begin : g_baud
      assign pre_f = tg_pkg::baud_pre_f(pre_code);
      assign scl_f = tg_pkg::baud_scl_f(scl_code);
    end
  endgenerate

  assign length = CNT_W'(pre_f) * CNT_W'(scl_f);
endmodule

// File: rtl/tg_sck_divider.sv
`timescale 1ns/1ps
module tg_sck_divider #(
  parameter int CNT_W = tg_pkg::TG_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             sck,
  output logic             tick
);
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] phase_len;
  logic [CNT_W-1:0] cnt;

  // High phase gets the floor of half, low phase the rest.
  assign half_len  = period >> 1;
  assign low_len   = period - half_len;
  assign phase_len = sck ? half_len : low_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sck  <= 1'b0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sck  <= 1'b0;
      tick <= 1'b0;
    end else if (cnt == phase_len - 1'b1) begin
      cnt  <= '0;
      sck  <= ~sck;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/tg_interval_timer.sv
`timescale 1ns/1ps
module tg_interval_timer #(
  parameter int CNT_W = tg_pkg::TG_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] length,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remain <= length - 1'b1;
        busy   <= 1'b1;
      end else if (busy) begin
        if (remain == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sckgen_timing.sv
`timescale 1ns/1ps
module sckgen_timing #(
  parameter int CFG_W = 32,
  parameter int CNT_W = tg_pkg::TG_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             run_i,
  input  logic             lead_start_i,
  input  logic             trail_start_i,
  output logic             sck_o,
  output logic             sck_tick_o,
  output logic             lead_done_o,
  output logic             trail_done_o
);
  import tg_pkg::*;

  localparam int N_TMR = 2;

  logic [CFG_W-1:0] cfg_q;
  logic             lead_busy;
  logic             trail_busy;
  logic             idle;
  logic [CNT_W-1:0] baud_len;
  logic [N_TMR-1:0] tmr_start;
  logic [N_TMR-1:0] tmr_busy;
  logic [N_TMR-1:0] tmr_done;

  assign idle = !run_i && !lead_busy && !trail_busy;

  // Capture the configuration only while nothing is in progress.
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (idle) cfg_q <= cfg_i;
  end

  tg_factor_decode #(.CNT_W(CNT_W), .DELAY(1'b0)) u_baud_dec (
    .pre_code (cfg_q[BAUD_PRE_LSB +: 2]),
    .scl_code (cfg_q[BAUD_SCL_LSB +: 4]),
    .length   (baud_len)
  );

  tg_sck_divider #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (run_i),
    .period (baud_len),
    .sck    (sck_o),
    .tick   (sck_tick_o)
  );

  assign tmr_start = {trail_start_i, lead_start_i};

  // Index 0 is the lead interval, index 1 the trail interval.
  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int PRE_LSB = (g == 0) ? LEAD_PRE_LSB : TRAIL_PRE_LSB;
    localparam int SCL_LSB = (g == 0) ? LEAD_SCL_LSB : TRAIL_SCL_LSB;
    logic [CNT_W-1:0] dly_len;

    tg_factor_decode #(.CNT_W(CNT_W), .DELAY(1'b1)) u_dec (
      .pre_code (cfg_q[PRE_LSB +: 2]),
      .scl_code (cfg_q[SCL_LSB +: 4]),
      .length   (dly_len)
    );

    tg_interval_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .start  (tmr_start[g]),
      .length (dly_len),
      .busy   (tmr_busy[g]),
      .done   (tmr_done[g])
    );
  end

  assign lead_busy    = tmr_busy[0];
  assign trail_busy   = tmr_busy[1];
  assign lead_done_o  = tmr_done[0];
  assign trail_done_o = tmr_done[1];
endmodule

// File: rtl/sckgen_timing_chk.sv
`timescale 1ns/1ps
module sckgen_timing_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic             lead_start_i,
  input logic             trail_start_i,
  input logic             sck_o,
  input logic             sck_tick_o,
  input logic             lead_done_o,
  input logic             trail_done_o,
  input logic             lead_busy,
  input logic             trail_busy,
  input logic [CFG_W-1:0] cfg_q
);
  // R4
  tick_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    sck_tick_o |-> (sck_o != $past(sck_o)));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !sck_o);

  // R5
  lead_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    lead_done_o |=> !lead_done_o);

  // R6
  trail_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trail_done_o |=> !trail_done_o);

  // R7
  lead_restart_chk: assert property (@(posedge clk) disable iff (rst)
    lead_start_i |=> (!lead_done_o && lead_busy));

  // R7
  trail_restart_chk: assert property (@(posedge clk) disable iff (rst)
    trail_start_i |=> (!trail_done_o && trail_busy));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i || lead_busy || trail_busy) |=> $stable(cfg_q));

  // R5
  lead_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    lead_done_o |-> !lead_busy);
endmodule

bind sckgen_timing sckgen_timing_chk #(.CFG_W(CFG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .run_i         (run_i),
  .lead_start_i  (lead_start_i),
  .trail_start_i (trail_start_i),
  .sck_o         (sck_o),
  .sck_tick_o    (sck_tick_o),
  .lead_done_o   (lead_done_o),
  .trail_done_o  (trail_done_o),
  .lead_busy     (lead_busy),
  .trail_busy    (trail_busy),
  .cfg_q         (cfg_q)
);

// File: tb/sckgen_timing_test.sv
`timescale 1ns/1ps
module sckgen_timing_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_i = '0;
  logic        run_i = 1'b0;
  logic        lead_start_i = 1'b0;
  logic        trail_start_i = 1'b0;
  logic        sck_o, sck_tick_o, lead_done_o, trail_done_o;

  int checks = 0;
  int errors = 0;
  int seed_v;

  always #2 clk = ~clk;

  sckgen_timing uut (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .run_i(run_i),
    .lead_start_i(lead_start_i), .trail_start_i(trail_start_i),
    .sck_o(sck_o), .sck_tick_o(sck_tick_o),
    .lead_done_o(lead_done_o), .trail_done_o(trail_done_o)
  );

  function automatic int bpre(input int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int bscl(input int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << c;
  endfunction
  function automatic int exp_period(input logic [31:0] c);
    return bpre(int'(c[17:16])) * bscl(int'(c[3:0]));
  endfunction
  function automatic int exp_lead(input logic [31:0] c);
    return (2 * int'(c[23:22]) + 1) * (2 << int'(c[15:12]));
  endfunction
  function automatic int exp_trail(input logic [31:0] c);
    return (2 * int'(c[21:20]) + 1) * (2 << int'(c[11:8]));
  endfunction
  function automatic logic [31:0] mk_cfg(input int bp, input int bs, input int lp,
                                          input int ls, input int tp, input int ts);
    logic [31:0] r = '0;
    r[17:16] = 2'(bp); r[3:0]   = 4'(bs);
    r[23:22] = 2'(lp); r[15:12] = 4'(ls);
    r[21:20] = 2'(tp); r[11:8]  = 4'(ts);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [31:0] c);
    cfg_i = c;
    repeat (2) @(negedge clk);
  endtask

  // Measures the first rise, fall and second rise of a run, then stops it.
  task automatic measure_sck(input logic [31:0] c, input string tag);
    int p, h, l, k, t1, t2, t3, ticks;
    p = exp_period(c); h = p / 2; l = p - h;
    set_cfg(c);
    run_i = 1'b1; k = 0; t1 = -1; t2 = -1; t3 = -1; ticks = 0;
    while (t3 < 0 && k < 5000) begin
      @(negedge clk); k++;
      if (sck_tick_o) ticks++;
      if (t1 < 0 && sck_o) t1 = k;
      else if (t1 >= 0 && t2 < 0 && !sck_o) t2 = k;
      else if (t2 >= 0 && sck_o) t3 = k;
    end
    check(t1 == l, {tag, " R2 R3 first rise"}, t1, l);
    check(t2 == l + h, {tag, " R3 fall"}, t2, l + h);
    check(t3 == 2 * l + h, {tag, " R2 period"}, t3 - t1, p);
    check(ticks == 3, {tag, " R4 tick count"}, ticks, 3);
    run_i = 1'b0;
    @(negedge clk);
    check(!sck_o && !sck_tick_o, {tag, " R9 stop low"}, int'(sck_o), 0);
  endtask

  // Pulses one start and returns the cycles until its done pulse.
  task automatic run_delay(input bit trail, output int k);
    if (trail) trail_start_i = 1'b1; else lead_start_i = 1'b1;
    @(negedge clk);
    trail_start_i = 1'b0; lead_start_i = 1'b0;
    k = 0;
    while (!(trail ? trail_done_o : lead_done_o) && k < 600000) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic measure_delays(input logic [31:0] c, input string tag);
    int k;
    set_cfg(c);
    run_delay(1'b0, k);
    check(k == exp_lead(c), {tag, " R5 lead"}, k, exp_lead(c));
    @(negedge clk);
    check(!lead_done_o, {tag, " R5 lead single pulse"}, int'(lead_done_o), 0);
    run_delay(1'b1, k);
    check(k == exp_trail(c), {tag, " R6 trail"}, k, exp_trail(c));
    @(negedge clk);
    check(!trail_done_o, {tag, " R6 trail single pulse"}, int'(trail_done_o), 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, kl, kt, t, d_a, first;
    logic [31:0] ca, cb;
    seed_v = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!sck_o && !sck_tick_o && !lead_done_o && !trail_done_o,
          "R1 reset outputs", int'({sck_o, sck_tick_o, lead_done_o, trail_done_o}), 0);

    // Directed table corners.
    measure_sck(mk_cfg(0, 0, 0, 0, 0, 0), "min");
    measure_sck(mk_cfg(3, 3, 0, 0, 0, 0), "p7s8");
    measure_sck(mk_cfg(1, 4, 0, 0, 0, 0), "p3s16");
    measure_sck(mk_cfg(2, 2, 0, 0, 0, 0), "p5s6");
    measure_delays(mk_cfg(0, 0, 0, 0, 3, 5), "dly a");
    measure_delays(mk_cfg(0, 0, 2, 3, 1, 0), "dly b");

    // R8: config change during a run is ignored until idle.
    ca = mk_cfg(0, 1, 0, 0, 0, 0);   // period 8
    cb = mk_cfg(3, 2, 0, 0, 0, 0);   // period 42
    set_cfg(ca);
    run_i = 1'b1; k = 0; first = -1; t = -1;
    while (t < 0 && k < 200) begin
      @(negedge clk); k++;
      if (first < 0 && sck_o) begin first = k; cfg_i = cb; end
      else if (first >= 0 && !sck_o && t < 0) t = k;
    end
    check(t == 8, "R8 period frozen during run", t, 8);
    run_i = 1'b0;
    measure_sck(cb, "R8 new cfg after idle");

    // R9: stop mid low phase, then full low phase again.
    set_cfg(mk_cfg(3, 3, 0, 0, 0, 0)); // period 56, low 28
    run_i = 1'b1;
    repeat (10) @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    run_i = 1'b1; k = 0;
    while (!sck_o && k < 200) begin @(negedge clk); k++; end
    check(k == 28, "R9 restart full low phase", k, 28);
    run_i = 1'b0;
    @(negedge clk);

    // R8: delay config change during counting.
    ca = mk_cfg(0, 0, 1, 2, 0, 0);   // lead 24
    cb = mk_cfg(0, 0, 3, 4, 0, 0);   // lead 224
    set_cfg(ca);
    lead_start_i = 1'b1;
    @(negedge clk);
    lead_start_i = 1'b0; cfg_i = cb; k = 0;
    while (!lead_done_o && k < 1000) begin @(negedge clk); k++; end
    check(k == 24, "R8 lead frozen while counting", k, 24);
    measure_delays(cb, "R8 new delay cfg");

    // R7: restart while counting.
    set_cfg(mk_cfg(0, 0, 1, 2, 0, 0)); // lead 24
    lead_start_i = 1'b1;
    @(negedge clk);
    lead_start_i = 1'b0;
    d_a = 0;
    repeat (5) begin @(negedge clk); if (lead_done_o) d_a++; end
    run_delay(1'b0, k);
    check(d_a == 0, "R7 no done before restart", d_a, 0);
    check(k == 24, "R7 restart length", k, 24);

    // R10: both intervals overlap with a running clock.
    set_cfg(mk_cfg(0, 0, 0, 2, 1, 1)); // lead 8, trail 12
    run_i = 1'b1; lead_start_i = 1'b1; trail_start_i = 1'b1;
    @(negedge clk);
    lead_start_i = 1'b0; trail_start_i = 1'b0;
    k = 0; kl = -1; kt = -1;
    while ((kl < 0 || kt < 0) && k < 200) begin
      if (lead_done_o && kl < 0) kl = k;
      if (trail_done_o && kt < 0) kt = k;
      @(negedge clk); k++;
    end
    check(kl == 8, "R10 lead concurrent", kl, 8);
    check(kt == 12, "R10 trail concurrent", kt, 12);
    run_i = 1'b0;
    repeat (2) @(negedge clk);

    // Constrained random mix.
    for (int i = 0; i < 10; i++) begin
      ca = mk_cfg(int'($urandom_range(3)), int'($urandom_range(5)),
                  int'($urandom_range(3)), int'($urandom_range(6)),
                  int'($urandom_range(3)), int'($urandom_range(6)));
      measure_sck(ca, "rand");
      measure_delays(ca, "rand");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule